// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block sits beside an 8-bit CPU with a 16-bit address bus and turns each memory access into one chip select: a monitor ROM, a bank of eight paged ROMs, or DRAM. For DRAM accesses it also drives the extra bank bits that take the DRAM beyond 64K. A page register that can only be written holds a RAM page number and a ROM page number. The CPU loads it with an I/O write to one fixed port.

A mode input picks one of two maps. In ROM mode the bottom 16K is ROM: a fixed 8K monitor sits at the base, and one of eight paged 8K ROMs sits above it. The 32K from 4000h to BFFFh is RAM, banked by the RAM page. In all-RAM mode every ROM is switched off and the whole 48K below C000h is banked RAM. In both modes the top 16K is one common RAM block. It always maps to bank 0, so RAM page 0 gives one contiguous run of RAM up to FFFFh.

Top module: `bank_map_decoder`

## Requirements
- R1: After reset the page register holds zero. In ROM mode, an access to 2000h then gives paged ROM 0, and an access to 4000h gives RAM bank 0.
- R2: The page register loads only on a clock edge where `io_wr` is high and `io_addr` equals the port parameter (default 00h). A write to any other port address leaves the register unchanged.
- R3: Bits [3:0] of the written byte set the RAM page and bits [6:4] set the ROM page. Bit 7 is ignored.
- R4: In ROM mode (`all_ram_mode`=0) with `mem_req` high, 0000h–1FFFh asserts only `mon_rom_sel`.
- R5: In ROM mode with `mem_req` high, 2000h–3FFFh asserts only `page_rom_sel`, and `rom_bank` equals the ROM page.
- R6: In ROM mode with `mem_req` high, 4000h–BFFFh asserts only `ram_sel`, and `ram_bank` equals the RAM page.
- R7: In all-RAM mode (`all_ram_mode`=1) with `mem_req` high, 0000h–BFFFh asserts only `ram_sel` with `ram_bank` equal to the RAM page. No ROM select is ever asserted in this mode.
- R8: In either mode, C000h–FFFFh with `mem_req` high asserts only `ram_sel` with `ram_bank`=0, whatever the RAM page.
- R9: While `mem_req` is low, all three selects, `rom_bank` and `ram_bank` are zero.
- R10: At most one of the three selects is high at any time. `rom_bank` is zero unless `page_rom_sel` is high, and `ram_bank` is zero unless `ram_sel` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 8 | I/O port address |
| io_data | input | 8 | I/O write data |
| all_ram_mode | input | 1 | 0 = ROM mode, 1 = all-RAM mode |
| mem_req | input | 1 | Memory request active (high) |
| cpu_addr | input | 16 | CPU address |
| mon_rom_sel | output | 1 | Monitor ROM select |
| page_rom_sel | output | 1 | Paged ROM select |
| rom_bank | output | 3 | Paged ROM number |
| ram_sel | output | 1 | DRAM select |
| ram_bank | output | 4 | DRAM bank bits |

## Verification
The bench checks every address boundary: 1FFFh/2000h, 3FFFh/4000h and BFFFh/C000h. A decoder that compares against the wrong address bit selects the wrong device on one side of a boundary. It sweeps all RAM and ROM pages in both modes, which catches a common block that follows the page (a non-zero `ram_bank` above C000h) and ROMs that stay visible in all-RAM mode. Writes that carry bit 7 set, or that go to the wrong port, catch field slicing that is off by one bit and port decoding that is too loose. Random accesses with `mem_req` low catch selects that ignore the request strobe.

// File: rtl/bmd_pkg.sv
package bmd_pkg;

  typedef enum logic [2:0] {
    RG_NONE   = 3'd0,
    RG_MON    = 3'd1,
    RG_PROM   = 3'd2,
    RG_PAGED  = 3'd3,
    RG_COMMON = 3'd4
  } region_e;

  // Region from the top three address bits, mode and request strobe.
  function automatic region_e classify(input logic all_ram, input logic req,
                                       input logic [2:0] hi3);
    region_e r;
    if (!req)                         r = RG_NONE;
    else if (hi3[2] && hi3[1])        r = RG_COMMON;
    else if (all_ram)                 r = RG_PAGED;
    else if (!hi3[2] && !hi3[1])      r = hi3[0] ? RG_PROM : RG_MON;
    else                              r = RG_PAGED;
    return r;
  endfunction

endpackage

// File: rtl/bmd_page_reg.sv
module bmd_page_reg #(
  parameter int IO_ADDR_W  = 8,
  parameter int DATA_W     = 8,
  parameter int RAM_PAGE_W = 4,
  parameter int ROM_PAGE_W = 3,
  parameter logic [IO_ADDR_W-1:0] PAGE_PORT = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  io_wr,
  input  logic [IO_ADDR_W-1:0]  io_addr,
  input  logic [DATA_W-1:0]     io_data,
  output logic [RAM_PAGE_W-1:0] ram_page,
  output logic [ROM_PAGE_W-1:0] rom_page
);
  localparam int FIELD_W = RAM_PAGE_W + ROM_PAGE_W;

  logic wr_hit;
  assign wr_hit = io_wr && (io_addr == PAGE_PORT);

  logic unused_data_bits;
  assign unused_data_bits = &{1'b0, io_data[DATA_W-1:FIELD_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_page <= '0;
      rom_page <= '0;
    end else if (wr_hit) begin
      ram_page <= io_data[RAM_PAGE_W-1:0];
      rom_page <= io_data[FIELD_W-1:RAM_PAGE_W];
    end
  end

  a_r2_hold_without_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> ($stable(ram_page) && $stable(rom_page)));

  a_r3_capture_fields: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (ram_page == $past(io_data[RAM_PAGE_W-1:0]) &&
                rom_page == $past(io_data[FIELD_W-1:RAM_PAGE_W])));

endmodule

// File: rtl/bmd_region_decode.sv
module bmd_region_decode
  import bmd_pkg::*;
(
  input  logic       all_ram_mode,
  input  logic       mem_req,
  input  logic [2:0] addr_hi3,
  output region_e    region
);
  always_comb region = classify(all_ram_mode, mem_req, addr_hi3);
endmodule

// File: rtl/bank_map_decoder.sv
module bank_map_decoder
  import bmd_pkg::*;
#(
  parameter int IO_ADDR_W  = 8,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 16,
  parameter int RAM_PAGE_W = 4,
  parameter int ROM_PAGE_W = 3,
  parameter logic [IO_ADDR_W-1:0] PAGE_PORT = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  io_wr,
  input  logic [IO_ADDR_W-1:0]  io_addr,
  input  logic [DATA_W-1:0]     io_data,
  input  logic                  all_ram_mode,
  input  logic                  mem_req,
  input  logic [ADDR_W-1:0]     cpu_addr,
  output logic                  mon_rom_sel,
  output logic                  page_rom_sel,
  output logic [ROM_PAGE_W-1:0] rom_bank,
  output logic                  ram_sel,
  output logic [RAM_PAGE_W-1:0] ram_bank
);
  localparam int HI_LSB = ADDR_W - 3;

  logic [RAM_PAGE_W-1:0] ram_page;
  logic [ROM_PAGE_W-1:0] rom_page;
  region_e               region;

  logic unused_addr_bits;
  assign unused_addr_bits = &{1'b0, cpu_addr[HI_LSB-1:0]};

  bmd_page_reg #(
    .IO_ADDR_W(IO_ADDR_W), .DATA_W(DATA_W), .RAM_PAGE_W(RAM_PAGE_W),
    .ROM_PAGE_W(ROM_PAGE_W), .PAGE_PORT(PAGE_PORT)
  ) page_reg_i (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_data(io_data), .ram_page(ram_page), .rom_page(rom_page)
  );

  bmd_region_decode region_i (
    .all_ram_mode(all_ram_mode), .mem_req(mem_req),
    .addr_hi3(cpu_addr[ADDR_W-1:HI_LSB]), .region(region)
  );

  always_comb begin
    mon_rom_sel  = (region == RG_MON);
    page_rom_sel = (region == RG_PROM);
    ram_sel      = (region == RG_PAGED) || (region == RG_COMMON);
    rom_bank     = page_rom_sel ? rom_page : '0;
    ram_bank     = (region == RG_PAGED) ? ram_page : '0;
  end

  a_r10_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mon_rom_sel, page_rom_sel, ram_sel}));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |-> !(mon_rom_sel || page_rom_sel || ram_sel) &&
                 rom_bank == '0 && ram_bank == '0);

  a_r8_common_block: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && cpu_addr[ADDR_W-1] && cpu_addr[ADDR_W-2]) |->
      (ram_sel && ram_bank == '0));

  a_r7_no_rom_all_ram: assert property (@(posedge clk) disable iff (!rst_n)
    all_ram_mode |-> !(mon_rom_sel || page_rom_sel));

  a_r4_monitor_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !all_ram_mode && cpu_addr[ADDR_W-1:HI_LSB] == 3'b000) |->
      mon_rom_sel);

endmodule

// File: tb/bank_map_decoder_tb_top.sv
module bank_map_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] PORT = 8'h00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_wr = 1'b0;
  logic [7:0] io_addr = '0;
  logic [7:0] io_data = '0;
  logic all_ram_mode = 1'b0;
  logic mem_req = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic mon_rom_sel, page_rom_sel, ram_sel;
  logic [2:0] rom_bank;
  logic [3:0] ram_bank;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  logic [3:0] sh_ram = '0;
  logic [2:0] sh_rom = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_map_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_data(io_data), .all_ram_mode(all_ram_mode), .mem_req(mem_req),
    .cpu_addr(cpu_addr), .mon_rom_sel(mon_rom_sel),
    .page_rom_sel(page_rom_sel), .rom_bank(rom_bank), .ram_sel(ram_sel),
    .ram_bank(ram_bank)
  );

  // Expected {mon, prom, rom_bank[2:0], ram, ram_bank[3:0]}
  function automatic logic [9:0] ref_map(logic mode, logic req, logic [15:0] a,
                                         logic [3:0] pr, logic [2:0] po);
    logic [9:0] e = '0;
    if (req) begin
      if (a >= 16'hC000)                 e = {1'b0, 1'b0, 3'd0, 1'b1, 4'd0};
      else if (mode || a >= 16'h4000)    e = {1'b0, 1'b0, 3'd0, 1'b1, pr};
      else if (a < 16'h2000)             e = {1'b1, 1'b0, 3'd0, 1'b0, 4'd0};
      else                               e = {1'b0, 1'b1, po, 1'b0, 4'd0};
    end
    return e;
  endfunction

  function automatic string tag_of(logic mode, logic req, logic [15:0] a);
    if (!req) return "R9";
    if (a >= 16'hC000) return "R8";
    if (mode) return "R7";
    if (a >= 16'h4000) return "R6";
    if (a >= 16'h2000) return "R5";
    return "R4";
  endfunction

  task automatic port_write(input logic [7:0] pa, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = pa; io_data = d;
    @(negedge clk);
    io_wr = 1'b0;
    if (pa == PORT) begin
      sh_ram = d[3:0];
      sh_rom = d[6:4];
    end
  endtask

  task automatic probe(input logic mode, input logic req, input logic [15:0] a,
                       input string tag);
    logic [9:0] exp_v, act_v;
    @(negedge clk);
    all_ram_mode = mode; mem_req = req; cpu_addr = a;
    #1;
    exp_v = ref_map(mode, req, a, sh_ram, sh_rom);
    act_v = {mon_rom_sel, page_rom_sel, rom_bank, ram_sel, ram_bank};
    compared++;
    if (act_v !== exp_v) begin
      mismatched++;
      $display("FAIL %s mode=%0d req=%0d addr=%h actual=%b expected=%b",
               tag, mode, req, a, act_v, exp_v);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [15:0] edges [8];
    edges = '{16'h0000, 16'h1FFF, 16'h2000, 16'h3FFF,
              16'h4000, 16'hBFFF, 16'hC000, 16'hFFFF};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    probe(1'b0, 1'b1, 16'h2000, "R1");
    probe(1'b0, 1'b1, 16'h4000, "R1");

    // R3: bit 7 ignored, fields sliced
    port_write(PORT, 8'hFF);
    probe(1'b0, 1'b1, 16'h2345, "R3");
    probe(1'b0, 1'b1, 16'h8000, "R3");
    port_write(PORT, 8'h5A);
    probe(1'b0, 1'b1, 16'h3000, "R3");
    probe(1'b1, 1'b1, 16'h0100, "R3");

    // R2: write to another port ignored
    port_write(8'h01, 8'h00);
    probe(1'b0, 1'b1, 16'h3000, "R2");
    probe(1'b0, 1'b1, 16'h7000, "R2");
    port_write(8'h80, 8'h33);
    probe(1'b1, 1'b1, 16'hBFFF, "R2");

    // Sweep all pages, both modes, boundaries (R4..R8, R10)
    for (int p = 0; p < 16; p++) begin
      for (int r = 0; r < 8; r++) begin
        port_write(PORT, {1'b0, r[2:0], p[3:0]});
        for (int m = 0; m < 2; m++)
          for (int e = 0; e < 8; e++)
            probe(m[0], 1'b1, edges[e], tag_of(m[0], 1'b1, edges[e]));
      end
    end

    // Random mix, including idle requests (R9) and stray port writes (R2)
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 3) == 0)
        port_write(($urandom_range(0, 2) == 0) ? 8'($urandom) : PORT,
                   8'($urandom));
      begin
        logic md, rq;
        logic [15:0] ad;
        md = 1'($urandom);
        rq = ($urandom_range(0, 3) != 0);
        ad = 16'($urandom);
        probe(md, rq, ad, tag_of(md, rq, ad));
      end
    end

    // R9 directed, R10 exclusivity is part of every compare
    probe(1'b0, 1'b0, 16'h0000, "R9");
    probe(1'b0, 1'b0, 16'h2000, "R9");
    probe(1'b1, 1'b0, 16'hC000, "R10");

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule